// File: doc/BRIEF.md
# Collision Backoff Scheduler for a Half-Duplex Ethernet Transmitter

This block sits beside a half-duplex Ethernet transmitter and decides when a frame that met a collision may be sent again. It follows the attempts made for the frame in flight. After every accepted collision it takes a random slot count from a free-running LFSR, narrowed to a window whose width grows with the attempt number, and then counts that many slot times before it signals that the retry may go.

The width of the window is held below a ceiling that software chooses from four codes. A single-attempt mode gives up the frame at its first collision. The attempt count also has a hard limit, and reaching it gives up the frame as well. In both cases the block reports an excessive-collision abort. When the link runs full duplex, collisions cannot occur, so the collision input is ignored completely.

Top module: `csma_backoff_ctrl`

## Requirements
- R1: One slot lasts SLOT_BITS bit-time ticks. A drawn wait of r slots raises `retry_go` exactly r*SLOT_BITS+1 clock edges after the edge that sampled the collision, provided `bit_tick` stays high. A draw of r = 0 therefore raises it on the very next edge.
- R2: The window exponent is k = min(n, L). Here n is the number of collisions so far in the frame, counting the current one. L is set by `limit_code`: 2'b00 gives 10, 2'b01 gives 8, 2'b10 gives 4 and 2'b11 gives 1. The drawn r always lies in 0 to 2^k-1.
- R3: While `single_shot` is 1, the first accepted collision raises `abort_xcol` on the edge that samples it, and no `retry_go` follows.
- R4: While `full_duplex` is 1, `collision` produces neither `retry_go` nor `abort_xcol`, and it does not count as an attempt.
- R5: With `single_shot` at 0, the first 15 accepted collisions of a frame each lead to one `retry_go`. The 16th accepted collision raises `abort_xcol` instead.
- R6: The attempt count goes back to zero on `frame_start`, on `frame_done` and on an abort. After a restart, a frame again needs 16 collisions before it is aborted.
- R7: Both outputs are low after reset. Each output is a pulse one cycle wide, and the two outputs are never high in the same cycle.
- R8: A collision is accepted only while a frame is being sent, meaning after `frame_start` or `retry_go` and before `frame_done`. A collision at any other time has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_start | input | 1 | A new frame begins transmission |
| frame_done | input | 1 | The current frame was sent successfully |
| collision | input | 1 | A collision was detected during transmission |
| limit_code | input | 2 | Selects the ceiling on the backoff exponent |
| single_shot | input | 1 | Abort on the first collision and never retry |
| full_duplex | input | 1 | Full-duplex link; collisions are ignored |
| bit_tick | input | 1 | One pulse per line bit time |
| retry_go | output | 1 | One-cycle grant to retransmit |
| abort_xcol | output | 1 | One-cycle abort with excessive-collision status |

## Verification
An abort is decided on the same edge that samples the collision. A retry grant appears r*SLOT_BITS+1 edges after that edge. The bench raises inputs at a falling edge, lowers them at the next falling edge, and reads `abort_xcol` at once. It then counts falling edges until `retry_go` appears. From that count it recovers r and checks two things: that the count is a whole number of slots plus one, and that r lies below the bound it works out for itself from the attempt number and the limit code. Every pulse is also checked to be low again one cycle later.

// File: rtl/bkoff_pkg.sv
package bkoff_pkg;
  localparam int unsigned MAX_EXP = 10;

  // exponent ceiling chosen by the limit code
  function automatic int unsigned exp_cap(input logic [1:0] code);
    case (code)
      2'b00:   return 10;
      2'b01:   return 8;
      2'b10:   return 4;
      default: return 1;
    endcase
  endfunction

  // k = min(n, cap); mask keeps the low k bits
  function automatic logic [MAX_EXP-1:0] draw_mask(input int unsigned n,
                                                   input logic [1:0] code);
    int unsigned k;
    logic [MAX_EXP-1:0] m;
    k = (n < exp_cap(code)) ? n : exp_cap(code);
    m = '0;
    for (int i = 0; i < int'(MAX_EXP); i++)
      if (i < int'(k)) m[i] = 1'b1;
    return m;
  endfunction

  typedef enum logic [1:0] {ST_IDLE, ST_SEND, ST_WAIT} bk_state_e;
endpackage

// File: rtl/bkoff_lfsr.sv
module bkoff_lfsr #(
  parameter int unsigned WIDTH = 16,
  parameter logic [WIDTH-1:0] TAPS = 16'hB400,
  parameter logic [WIDTH-1:0] SEED = 16'hACE1
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic [WIDTH-1:0] state_o
);
  logic [WIDTH-1:0] s_q;

  always_ff @(posedge clk) begin
    if (!rst_n) s_q <= SEED;
    else if (s_q[0]) s_q <= (s_q >> 1) ^ TAPS;
    else s_q <= s_q >> 1;
  end

  assign state_o = s_q;

  a_r2_lfsr_alive: assert property (@(posedge clk) disable iff (!rst_n)
    s_q != '0);
endmodule

// File: rtl/bkoff_attempts.sv
module bkoff_attempts
  import bkoff_pkg::*;
#(
  parameter int unsigned MAX_ATTEMPTS = 16,
  localparam int unsigned ATT_W = $clog2(MAX_ATTEMPTS + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 frame_start,
  input  logic                 frame_done,
  input  logic                 collision,
  input  logic                 full_duplex,
  input  logic                 single_shot,
  input  logic [1:0]           limit_code,
  input  logic                 wait_over,
  output logic                 start_wait,
  output logic [MAX_EXP-1:0]   mask_o,
  output logic                 abort_o
);
  bk_state_e        st_q;
  logic [ATT_W-1:0] att_q;
  logic [ATT_W-1:0] att_next;
  logic             col_taken;
  logic             give_up;
  logic             abort_q;

  assign col_taken  = (st_q == ST_SEND) && collision && !full_duplex
                      && !frame_start && !frame_done;
  assign att_next   = att_q + 1'b1;
  assign give_up    = single_shot || (att_next >= ATT_W'(MAX_ATTEMPTS));
  assign start_wait = col_taken && !give_up;
  assign mask_o     = draw_mask(32'(att_next), limit_code);
  assign abort_o    = abort_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      att_q   <= '0;
      abort_q <= 1'b0;
    end else begin
      abort_q <= col_taken && give_up;
      if (frame_start) begin
        st_q  <= ST_SEND;
        att_q <= '0;
      end else begin
        case (st_q)
          ST_SEND: begin
            if (frame_done) begin
              st_q  <= ST_IDLE;
              att_q <= '0;
            end else if (col_taken) begin
              if (give_up) begin
                st_q  <= ST_IDLE;
                att_q <= '0;
              end else begin
                st_q  <= ST_WAIT;
                att_q <= att_next;
              end
            end
          end
          ST_WAIT: if (wait_over) st_q <= ST_SEND;
          default: st_q <= ST_IDLE;
        endcase
      end
    end
  end

  a_r5_attempt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    att_q < ATT_W'(MAX_ATTEMPTS));
  a_r3_single_abort: assert property (@(posedge clk) disable iff (!rst_n)
    (col_taken && single_shot) |=> abort_o);
  a_r4_duplex_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (full_duplex && collision) |=> !abort_o);
  a_r8_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_IDLE) |=> !abort_o);
endmodule

// File: rtl/bkoff_slot_timer.sv
module bkoff_slot_timer
  import bkoff_pkg::*;
#(
  parameter int unsigned SLOT_BITS = 512,
  localparam int unsigned BIT_W = $clog2(SLOT_BITS)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cancel,
  input  logic               load,
  input  logic [MAX_EXP-1:0] slots_in,
  input  logic               bit_tick,
  output logic               expire,
  output logic               go_o
);
  logic               active_q;
  logic [MAX_EXP-1:0] slots_q;
  logic [BIT_W-1:0]   bits_q;
  logic               go_q;

  assign expire = active_q && (slots_q == '0) && !cancel;
  assign go_o   = go_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      slots_q  <= '0;
      bits_q   <= '0;
      go_q     <= 1'b0;
    end else if (cancel) begin
      active_q <= 1'b0;
      go_q     <= 1'b0;
    end else if (load) begin
      active_q <= 1'b1;
      slots_q  <= slots_in;
      bits_q   <= '0;
      go_q     <= 1'b0;
    end else if (active_q) begin
      if (slots_q == '0) begin
        active_q <= 1'b0;
        go_q     <= 1'b1;
      end else begin
        go_q <= 1'b0;
        if (bit_tick) begin
          if (bits_q == BIT_W'(SLOT_BITS - 1)) begin
            bits_q  <= '0;
            slots_q <= slots_q - 1'b1;
          end else begin
            bits_q <= bits_q + 1'b1;
          end
        end
      end
    end else begin
      go_q <= 1'b0;
    end
  end

  a_r7_go_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    go_o |=> !go_o);
  a_r1_hold_no_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (active_q && !bit_tick && !load && !cancel && slots_q != '0)
      |=> $stable(slots_q));
endmodule

// File: rtl/csma_backoff_ctrl.sv
module csma_backoff_ctrl
  import bkoff_pkg::*;
#(
  parameter int unsigned SLOT_BITS    = 512,
  parameter int unsigned MAX_ATTEMPTS = 16,
  parameter int unsigned LFSR_W       = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       frame_start,
  input  logic       frame_done,
  input  logic       collision,
  input  logic [1:0] limit_code,
  input  logic       single_shot,
  input  logic       full_duplex,
  input  logic       bit_tick,
  output logic       retry_go,
  output logic       abort_xcol
);
  logic [LFSR_W-1:0]  rnd;
  logic               start_wait;
  logic [MAX_EXP-1:0] mask;
  logic [MAX_EXP-1:0] draw;
  logic               wait_over;

  bkoff_lfsr #(.WIDTH(LFSR_W), .TAPS(LFSR_W'(16'hB400)), .SEED(LFSR_W'(16'hACE1)))
    u_lfsr (.clk(clk), .rst_n(rst_n), .state_o(rnd));

  bkoff_attempts #(.MAX_ATTEMPTS(MAX_ATTEMPTS)) u_att (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .frame_done(frame_done),
    .collision(collision), .full_duplex(full_duplex), .single_shot(single_shot),
    .limit_code(limit_code), .wait_over(wait_over), .start_wait(start_wait),
    .mask_o(mask), .abort_o(abort_xcol));

  assign draw = rnd[MAX_EXP-1:0] & mask;

  bkoff_slot_timer #(.SLOT_BITS(SLOT_BITS)) u_tmr (
    .clk(clk), .rst_n(rst_n), .cancel(frame_start), .load(start_wait),
    .slots_in(draw), .bit_tick(bit_tick), .expire(wait_over), .go_o(retry_go));

  a_r7_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(retry_go && abort_xcol));
  a_r7_abort_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    abort_xcol |=> !abort_xcol);
  a_r2_draw_range: assert property (@(posedge clk) disable iff (!rst_n)
    start_wait |-> ((draw >> MAX_EXP'(exp_cap(limit_code))) == '0));
endmodule

// File: tb/tb_csma_backoff_ctrl.sv
module tb_csma_backoff_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int SB = 8;

  logic clk = 0, rst_n = 0;
  logic frame_start = 0, frame_done = 0, collision = 0;
  logic [1:0] limit_code = 0;
  logic single_shot = 0, full_duplex = 0, bit_tick = 1;
  logic retry_go, abort_xcol;
  int n_chk = 0, n_bad = 0;

  csma_backoff_ctrl #(.SLOT_BITS(SB)) dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  // {limit_code[1:0], collisions[5:0]}
  localparam logic [7:0] VEC [4] = '{ {2'b00, 6'd10}, {2'b01, 6'd9},
                                      {2'b10, 6'd6},  {2'b11, 6'd4} };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int bound(input int n, input int code);
    int cap, k;
    cap = (code == 0) ? 10 : (code == 1) ? 8 : (code == 2) ? 4 : 1;
    k = (n < cap) ? n : cap;
    return (1 << k) - 1;
  endfunction

  task automatic pulse_start();
    @(negedge clk) frame_start = 1;
    @(negedge clk) frame_start = 0;
  endtask

  // result: 0 retry, 1 abort, 2 nothing; cyc = edges until retry
  task automatic collide(input int limit, output int res, output int cyc);
    @(negedge clk) collision = 1;
    @(negedge clk) collision = 0;
    cyc = 0; res = 2;
    if (abort_xcol) begin res = 1; return; end
    while (cyc < limit) begin
      @(negedge clk); cyc++;
      if (abort_xcol) begin res = 1; return; end
      if (retry_go) begin
        res = 0;
        @(negedge clk);
        check(!retry_go, "R7 retry pulse width", retry_go, 0);
        return;
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog R7 actual=timeout expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int res, cyc, retries;
    repeat (3) @(negedge clk);
    check(retry_go == 0, "R7 reset retry_go", retry_go, 0);
    check(abort_xcol == 0, "R7 reset abort_xcol", abort_xcol, 0);
    rst_n = 1;

    // R8: a collision while idle is ignored
    @(negedge clk);
    collide(40, res, cyc);
    check(res == 2, "R8 idle collision ignored", res, 2);

    // R1/R2: table walk
    foreach (VEC[v]) begin
      limit_code = VEC[v][7:6];
      pulse_start();
      for (int a = 1; a <= int'(VEC[v][5:0]); a++) begin
        collide(1024*SB + 20, res, cyc);
        check(res == 0, "R1 retry granted", res, 0);
        check((cyc - 1) % SB == 0, "R1 slot alignment", (cyc - 1) % SB, 0);
        check((cyc - 1) / SB <= bound(a, limit_code), "R2 draw within window",
              (cyc - 1) / SB, bound(a, limit_code));
      end
      @(negedge clk) frame_done = 1;
      @(negedge clk) frame_done = 0;
    end

    // R8: a collision after frame_done is ignored
    collide(40, res, cyc);
    check(res == 2, "R8 post-success collision ignored", res, 2);

    // R3: single shot
    single_shot = 1; limit_code = 2'b11;
    pulse_start();
    collide(40, res, cyc);
    check(res == 1 && cyc == 0, "R3 abort on first collision", res, 1);
    @(negedge clk);
    check(abort_xcol == 0, "R7 abort pulse width", abort_xcol, 0);
    repeat (30) begin
      @(negedge clk);
      if (retry_go) check(0, "R3 no retry after abort", 1, 0);
    end
    single_shot = 0;

    // R4: full duplex ignores collisions
    full_duplex = 1; limit_code = 2'b00;
    pulse_start();
    collide(40, res, cyc);
    check(res == 2, "R4 full-duplex collision ignored", res, 2);
    full_duplex = 0;
    collide(1024*SB + 20, res, cyc);
    check(res == 0 && (cyc - 1) / SB <= 1, "R4 first counted attempt", (cyc - 1) / SB, 1);

    // R5: 15 retries then abort
    limit_code = 2'b11;
    pulse_start();
    retries = 0;
    for (int a = 1; a <= 16; a++) begin
      collide(4*SB, res, cyc);
      if (a < 16 && res == 0) retries++;
      if (a == 16) check(res == 1, "R5 abort on 16th collision", res, 1);
    end
    check(retries == 15, "R5 retry count", retries, 15);

    // R6: frame_start clears attempt count
    pulse_start();
    for (int a = 1; a <= 10; a++) collide(4*SB, res, cyc);
    pulse_start();
    retries = 0;
    for (int a = 1; a <= 16; a++) begin
      collide(4*SB, res, cyc);
      if (a < 16 && res == 0) retries++;
      if (a == 16) check(res == 1, "R6 abort after full restart", res, 1);
    end
    check(retries == 15, "R6 retries after restart", retries, 15);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule